// File: doc/BRIEF.md
# Synchronous Burst-Style SRAM Data Path

This block is the data path of a single-port synchronous memory: a byte-lane array plus the control that decides, each clock, whether a captured command reads, writes or deselects, and when the read data bus is driven. Address, chip selects, address load and write controls are taken on the rising clock edge. Burst addresses come from outside, so every cycle carries its own address.

Two static mode inputs shape the read side. `pipe_mode` picks flow-through reads, with data one edge after capture, or pipelined reads with one more registered stage. `late_off` picks how quickly the drivers turn off after a deselect: at once, or one cycle later. The data bus is modelled as a value output plus a drive-enable output (`rdata_oe`) in place of a tristate pin. An asynchronous active-low enable gates that drive.

A sleep request puts the block to sleep after two edges. The array keeps its contents and the outputs are released. When the request drops, a recovery window of `REC_CYC` cycles follows. In that window a write command is dropped and reported on `wr_err`.

Top module: `sram_sync_core`

## Requirements
- R1: With `pipe_mode`=0, a read captured at edge k drives the word at its address on `rdata` with `rdata_oe`=1 right after edge k.
- R2: With `pipe_mode`=1, a read captured at edge k first drives its word after edge k+1, one cycle later than in R1.
- R3: With `late_off`=0, the drive stops right after the edge that captures a deselect. In pipelined mode this cuts off the data of a read captured one edge earlier.
- R4: With `late_off`=1, a deselect captured at edge m leaves the drive of the previous read in place until edge m+1. It stops after that edge.
- R5: `all_wr_n`=0 writes every byte lane of the addressed word, whatever `lane_wr_n` and `lane_sel_n` hold.
- R6: With `all_wr_n`=1, `lane_wr_n`=0 writes only the lanes whose `lane_sel_n` bit is 0, where bit i covers `wdata[8i+7:8i]`. `lane_wr_n`=1, or all `lane_sel_n` bits at 1, is a read.
- R7: The drive is off after any edge that captures a write. A read drives all lanes whatever the lane selects hold.
- R8: `drv_en_n`=1 clears `rdata_oe` at once, with no clock edge. `drv_en_n`=0 raises it only while read data is due.
- R9: A command is selected when `sel_a_n`=0 on its edge and the pair (`sel_b`=1, `sel_c_n`=0) held at the last edge with `adr_load_n`=0. On edges with `adr_load_n`=1, `sel_b` and `sel_c_n` are ignored.
- R10: With `sleep_req`=1 at edges e and e+1, commands at those edges still run. The drive is off after e+1. Later commands are ignored until wake-up, and the array contents are kept.
- R11: Once sleep ends, the next `REC_CYC` commands after the first awake edge ignore writes. Each such write raises `wr_err` for one cycle after its edge. Reads run normally.
- R12: After reset, `rdata_oe`=0 and `wr_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| late_off | input | 1 | 1 = drive off one cycle after deselect, 0 = at once |
| addr | input | AW | Word address |
| sel_a_n | input | 1 | Select, active low, sampled every edge |
| sel_b | input | 1 | Select, active high, sampled on load edges |
| sel_c_n | input | 1 | Select, active low, sampled on load edges |
| adr_load_n | input | 1 | Address load strobe, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | DW | Write data |
| drv_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| rdata | output | DW | Read data |
| rdata_oe | output | 1 | Read bus drive enable |
| wr_err | output | 1 | Write refused during wake-up recovery |

## Verification
The hardest state to reach from the ports is the wake-up window. A write there must be refused and flagged, while the data stored before sleep must still be readable. The bench gets there by writing a word, then raising `sleep_req` under back-to-back reads, so it can see the edge where the drive stops. It tries writes during sleep, drops the request, and fires a write on the first counted recovery edge. It then reads the old word back and writes again just after the window closes. The mode table also steps a read into a deselect under each pairing of `pipe_mode` and `late_off`, to pin the exact cycle of turn-off.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ssram_ctl.sv
module ssram_ctl
  import ssram_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int REC_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             adr_load_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             sleep_req,
  output op_e              op_now,
  output logic [LANES-1:0] lane_we,
  output logic             asleep,
  output logic             rec_busy,
  output logic             wr_err
);
  localparam int RCW = $clog2(REC_CYC + 1);

  logic           hold_bc;
  logic           sel_bc;
  logic           selected;
  logic           wr_req;
  logic           nap_seen;
  logic [RCW-1:0] rec_cnt;

  // outer selects only count on load edges; otherwise the last capture holds
  assign sel_bc   = !adr_load_n ? (sel_b && !sel_c_n) : hold_bc;
  assign selected = !sel_a_n && sel_bc;
  assign wr_req   = !all_wr_n || (!lane_wr_n && (lane_sel_n != '1));
  assign rec_busy = (rec_cnt != '0);

  always_comb begin
    if (!selected || asleep)  op_now = OP_DESEL;
    else if (wr_req)          op_now = rec_busy ? OP_DESEL : OP_WRITE;
    else                      op_now = OP_READ;
  end

  always_comb begin
    if (op_now != OP_WRITE)   lane_we = '0;
    else if (!all_wr_n)       lane_we = '1;
    else                      lane_we = ~lane_sel_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_bc  <= 1'b0;
      nap_seen <= 1'b0;
      asleep   <= 1'b0;
      rec_cnt  <= '0;
      wr_err   <= 1'b0;
    end else begin
      if (!adr_load_n) hold_bc <= sel_b && !sel_c_n;
      nap_seen <= sleep_req;
      asleep   <= nap_seen;
      if (asleep && !nap_seen)  rec_cnt <= RCW'(REC_CYC);
      else if (rec_busy)        rec_cnt <= rec_cnt - 1'b1;
      wr_err   <= selected && !asleep && wr_req && rec_busy;
    end
  end
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdq
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LW +: LW];
      if (re)    q <= mem[addr];
    end
    assign rdq[g*LW +: LW] = q;
  end
endmodule

// File: rtl/ssram_outpath.sv
module ssram_outpath
  import ssram_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_mode,
  input  logic          late_off,
  input  op_e           op_now,
  input  logic          asleep,
  input  logic          drv_en_n,
  input  logic [DW-1:0] ramq,
  output op_e           cur_op,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  op_e           prev_op;
  logic [DW-1:0] outq;
  logic          due_ft;
  logic          due_pl;
  logic          drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_op  <= OP_DESEL;
      prev_op <= OP_DESEL;
    end else begin
      cur_op  <= op_now;
      prev_op <= cur_op;
    end
  end

  always_ff @(posedge clk) outq <= ramq;

  // flow-through: data of the stage-one read; late_off stretches it over one deselect
  assign due_ft = (cur_op == OP_READ) ||
                  (late_off && cur_op == OP_DESEL && prev_op == OP_READ);
  // pipelined: data of the stage-two read; early turn-off cuts it on a fresh deselect
  assign due_pl = (prev_op == OP_READ) && (late_off || cur_op != OP_DESEL);

  assign drive    = (pipe_mode ? due_pl : due_ft) && (cur_op != OP_WRITE) && !asleep;
  assign rdata_oe = drive && !drv_en_n;
  assign rdata    = pipe_mode ? outq : ramq;
endmodule

// File: rtl/sram_sync_core.sv
module sram_sync_core
  import ssram_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 32,
  parameter int LANES   = 4,
  parameter int REC_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pipe_mode,
  input  logic             late_off,
  input  logic [AW-1:0]    addr,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             adr_load_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [DW-1:0]    wdata,
  input  logic             drv_en_n,
  input  logic             sleep_req,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe,
  output logic             wr_err
);
  op_e              op_now;
  op_e              cur_op;
  logic [LANES-1:0] lane_we;
  logic             asleep;
  logic             rec_busy;
  logic [DW-1:0]    ramq;
  logic             cur_is_wr;

  assign cur_is_wr = (cur_op == OP_WRITE);

  ssram_ctl #(.LANES(LANES), .REC_CYC(REC_CYC)) u_ctl (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .adr_load_n(adr_load_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_sel_n(lane_sel_n), .sleep_req(sleep_req), .op_now(op_now),
    .lane_we(lane_we), .asleep(asleep), .rec_busy(rec_busy), .wr_err(wr_err)
  );

  ssram_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_arr (
    .clk(clk), .we(lane_we), .re(op_now == OP_READ), .addr(addr),
    .wdata(wdata), .rdq(ramq)
  );

  ssram_outpath #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .late_off(late_off),
    .op_now(op_now), .asleep(asleep), .drv_en_n(drv_en_n), .ramq(ramq),
    .cur_op(cur_op), .rdata(rdata), .rdata_oe(rdata_oe)
  );
endmodule

// File: rtl/sram_sync_core_chk.sv
module sram_sync_core_chk (
  input logic clk,
  input logic rst,
  input logic drv_en_n,
  input logic sleep_req,
  input logic rdata_oe,
  input logic wr_err,
  input logic asleep,
  input logic rec_busy,
  input logic cur_is_wr
);
  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> !drv_en_n);

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    cur_is_wr |-> !rdata_oe);

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    asleep |-> !rdata_oe);

  assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (rst)
    $past(sleep_req, 2) |-> asleep);

  assert_err_window_R11: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(rec_busy));
endmodule

bind sram_sync_core sram_sync_core_chk u_chk (
  .clk(clk), .rst(rst), .drv_en_n(drv_en_n), .sleep_req(sleep_req),
  .rdata_oe(rdata_oe), .wr_err(wr_err), .asleep(asleep),
  .rec_busy(rec_busy), .cur_is_wr(cur_is_wr)
);

// File: tb/sram_sync_core_tb.sv
`timescale 1ns/1ps
module sram_sync_core_tb;
  localparam int AW = 6, DW = 32, LANES = 4, REC_CYC = 3;
  localparam int NV = 27;

  typedef struct packed {
    logic        pipe;
    logic        late;
    logic        sa_n;
    logic        sb;
    logic        sc_n;
    logic        ld_n;
    logic        aw_n;
    logic        lw_n;
    logic [3:0]  ls_n;
    logic [5:0]  adr;
    logic [31:0] wd;
    logic        xoe;
    logic [31:0] xd;
    logic [3:0]  req;
  } vec_t;

  // fields: pipe late sa_n sb sc_n ld_n aw_n lw_n ls_n adr wd | exp_oe exp_data req
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,6'd1,32'hA5A50001,1'b0,32'h0,4'd5},  // R5 write all
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,6'd2,32'hFFFFFFFF,1'b0,32'h0,4'd5},  // R5
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'hA,6'd2,32'h11223344,1'b0,32'h0,4'd6},  // R6 lanes 0,2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd1,32'h0,1'b1,32'hA5A50001,4'd1},  // R1
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'hF,6'd2,32'h0,1'b1,32'hFF22FF44,4'd6},  // R6 no lane = read
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd0,32'h0,1'b0,32'h0,4'd3},         // R3 FT off
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd1,32'h0,1'b1,32'hA5A50001,4'd1},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd0,32'h0,1'b1,32'hA5A50001,4'd4},  // R4 held
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd0,32'h0,1'b0,32'h0,4'd4},         // R4 off
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd2,32'h0,1'b0,32'h0,4'd2},         // R2 not yet
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd0,32'h0,1'b1,32'hFF22FF44,4'd4},  // R4 PL
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd0,32'h0,1'b0,32'h0,4'd4},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd1,32'h0,1'b0,32'h0,4'd2},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd2,32'h0,1'b1,32'hA5A50001,4'd2},  // R2
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd0,32'h0,1'b0,32'h0,4'd3},         // R3 cut
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd1,32'h0,1'b0,32'h0,4'd3},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,6'd3,32'h0BADF00D,1'b0,32'h0,4'd7},  // R7 write quiet
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd3,32'h0,1'b0,32'h0,4'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd3,32'h0,1'b1,32'h0BADF00D,4'd2},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'hF,6'd1,32'h0,1'b0,32'h0,4'd9},         // R9 sb low
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'd1,32'h0,1'b0,32'h0,4'd9},         // R9 held off
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd2,32'h0,1'b0,32'h0,4'd9},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,6'd1,32'h0,1'b1,32'hFF22FF44,4'd9},  // R9 ignored pair
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'd3,32'h0,1'b1,32'hA5A50001,4'd9},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'd0,32'h0,1'b0,32'h0,4'd9},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'h0,6'd2,32'h0,1'b0,32'h0,4'd6},         // R6 lw_n high = read
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,6'd2,32'h0,1'b1,32'hFF22FF44,4'd6}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pipe_mode = 1'b0, late_off = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic             sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, adr_load_n = 1'b1;
  logic             all_wr_n = 1'b1, lane_wr_n = 1'b1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic [DW-1:0]    wdata = '0;
  logic             drv_en_n = 1'b0, sleep_req = 1'b0;
  logic [DW-1:0]    rdata;
  logic             rdata_oe, wr_err;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_sync_core #(.AW(AW), .DW(DW), .LANES(LANES), .REC_CYC(REC_CYC)) u_dut (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .late_off(late_off), .addr(addr),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adr_load_n(adr_load_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .wdata(wdata),
    .drv_en_n(drv_en_n), .sleep_req(sleep_req), .rdata(rdata), .rdata_oe(rdata_oe),
    .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic sa_n, input logic aw_n, input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_a_n = sa_n; sel_b = 1'b1; sel_c_n = 1'b0; adr_load_n = 1'b0;
    all_wr_n = aw_n; lane_wr_n = 1'b1; lane_sel_n = '1; addr = a; wdata = d;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(rdata_oe == 1'b0, "R12 oe after reset", 32'(rdata_oe), 32'h0);
    chk(wr_err == 1'b0, "R12 wr_err after reset", 32'(wr_err), 32'h0);

    for (int i = 0; i < NV; i++) begin
      pipe_mode = VECS[i].pipe; late_off = VECS[i].late;
      sel_a_n = VECS[i].sa_n; sel_b = VECS[i].sb; sel_c_n = VECS[i].sc_n;
      adr_load_n = VECS[i].ld_n; all_wr_n = VECS[i].aw_n; lane_wr_n = VECS[i].lw_n;
      lane_sel_n = VECS[i].ls_n; addr = VECS[i].adr; wdata = VECS[i].wd;
      tick();
      chk(rdata_oe == VECS[i].xoe, $sformatf("R%0d vec %0d oe", VECS[i].req, i),
          32'(rdata_oe), 32'(VECS[i].xoe));
      if (VECS[i].xoe)
        chk(rdata == VECS[i].xd, $sformatf("R%0d vec %0d data", VECS[i].req, i),
            rdata, VECS[i].xd);
    end

    // R8 asynchronous output enable, flow-through, early turn-off
    pipe_mode = 1'b0; late_off = 1'b0;
    cmd(1'b0, 1'b1, 6'd1, '0);
    tick();
    chk(rdata_oe == 1'b1, "R8 drive before gate", 32'(rdata_oe), 32'h1);
    drv_en_n = 1'b1; #1;
    chk(rdata_oe == 1'b0, "R8 gate off async", 32'(rdata_oe), 32'h0);
    drv_en_n = 1'b0; #1;
    chk(rdata_oe == 1'b1, "R8 gate back on", 32'(rdata_oe), 32'h1);
    cmd(1'b1, 1'b1, 6'd0, '0);
    tick();
    chk(rdata_oe == 1'b0, "R8 low enable without data", 32'(rdata_oe), 32'h0);

    // R10 sleep entry
    sleep_req = 1'b1;
    cmd(1'b0, 1'b1, 6'd1, '0);
    tick();
    chk(rdata_oe == 1'b1, "R10 still awake after first edge", 32'(rdata_oe), 32'h1);
    tick();
    chk(rdata_oe == 1'b0, "R10 off after second edge", 32'(rdata_oe), 32'h0);
    cmd(1'b0, 1'b0, 6'd1, 32'h0);
    tick();
    chk(rdata_oe == 1'b0, "R10 quiet while asleep", 32'(rdata_oe), 32'h0);
    chk(wr_err == 1'b0, "R10 no error while asleep", 32'(wr_err), 32'h0);
    tick();
    // R11 wake-up and recovery window
    sleep_req = 1'b0;
    cmd(1'b1, 1'b1, 6'd0, '0);
    tick();
    tick();
    cmd(1'b0, 1'b0, 6'd1, 32'h0);
    tick();
    chk(wr_err == 1'b1, "R11 write flagged in window", 32'(wr_err), 32'h1);
    cmd(1'b0, 1'b1, 6'd1, '0);
    tick();
    chk(wr_err == 1'b0, "R11 flag lasts one cycle", 32'(wr_err), 32'h0);
    chk(rdata == 32'hA5A50001, "R10 R11 contents kept", rdata, 32'hA5A50001);
    tick();
    cmd(1'b0, 1'b0, 6'd5, 32'h12345678);
    tick();
    chk(wr_err == 1'b0, "R11 write accepted after window", 32'(wr_err), 32'h0);
    cmd(1'b0, 1'b1, 6'd5, '0);
    tick();
    chk(rdata_oe == 1'b1 && rdata == 32'h12345678, "R11 post-window write landed",
        rdata, 32'h12345678);

    finish_run();
  end
endmodule